// File: doc/BRIEF.md
# Shared-Memory Doorbell Register Block

This block is the register front end of one node in a group of peers that share a memory region. Software reaches it through a simple 32-bit register bus decoding a 1 KB window. Inside that window there are four registers: an interrupt mask, an interrupt status, a read-only node identifier and a write-only doorbell. A doorbell write names a peer and a vector. The block turns it into an outbound event that the surrounding fabric routes to that peer.

Events addressed to this node arrive on an inbound port and are delivered in one of two ways, chosen by a static mode pin. In pin mode, the event sets a bit in the status register, and a level interrupt is raised while status is nonzero and the mask enables it. In message mode, the event pulses one of several per-vector outputs. A vector outside the supported range is discarded and recorded in a sticky error flag.

The outbound port uses a valid/ready handshake. Once raised, `out_valid` stays high and `out_dest`/`out_vec` stay unchanged until a cycle with `out_ready` high accepts the event. While an event is waiting, further doorbell writes are discarded, so back-pressure from the fabric drops requests rather than queueing them. The inbound port has no ready: an event presented with `in_valid` is consumed in that same cycle.

Top module: `shm_doorbell_regs`

## Requirements
- R1: The mask register sits at byte offset 0x0. It is 32 bits wide, resets to 0 and reads back the last value written. Accesses whose other offsets do not address it leave it unchanged.
- R2: The ID register sits at offset 0x8. It reads 0xFFFFFFFF while `id_ready` is low, and reads `node_id` zero-extended to 32 bits while `id_ready` is high. Writes to it have no effect.
- R3: The doorbell offset 0xC, offsets 0x10 to 0x3FC, and any address with bits 1:0 nonzero all read as zero. Writes to any of these addresses other than a doorbell write change no register.
- R4: A write to 0xC while `id_ready` is high and no event is pending raises `out_valid` in the next cycle. The event carries `out_dest` = write data bits 31:16 and `out_vec` = bits 15:0.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_dest` and `out_vec` hold. Doorbell writes in that state are discarded. `out_valid` falls in the cycle after a cycle with `out_ready` high, unless a new doorbell write loads a new event in that same cycle.
- R6: A doorbell write while `id_ready` is low produces no outbound event.
- R7: In pin mode (`msg_mode` low), an inbound event with vector v sets status bit v[4:0] at the next clock edge. Status is read at offset 0x4 and is not writable.
- R8: A read of the status register returns its current value and clears it at that clock edge. A bit set by an inbound event in the same cycle survives the clear.
- R9: `irq` is high exactly when status is nonzero and mask bit 0 is 1.
- R10: In message mode (`msg_mode` high), an inbound event with vector v below NUM_VEC (4) pulses `vec_pulse[v]` for exactly one cycle, starting the cycle after the event, and leaves status unchanged.
- R11: In message mode, an inbound event with vector at or above NUM_VEC produces no pulse and sets `vec_err`. `vec_err` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address inside the 1 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| node_id | input | 16 | This node's identifier |
| id_ready | input | 1 | Node identifier valid and shared region usable |
| msg_mode | input | 1 | 0 = pin delivery, 1 = per-vector pulses |
| in_valid | input | 1 | Inbound event present |
| in_vec | input | 16 | Inbound event vector |
| irq | output | 1 | Level interrupt (pin mode) |
| vec_pulse | output | 4 | One-cycle vector pulses (message mode) |
| vec_err | output | 1 | Sticky out-of-range vector flag |
| out_valid | output | 1 | Outbound event valid |
| out_ready | input | 1 | Outbound event accepted |
| out_dest | output | 16 | Outbound destination node |
| out_vec | output | 16 | Outbound vector |

## Verification
The assertions assume that `msg_mode` changes only while no inbound event is present. They also assume that `out_ready` is a plain acceptance signal, so the outbox may treat an accepted event as gone at the next edge. The stimulus keeps within these assumptions: it sets the mode between scenarios with `in_valid` low, and it raises `out_ready` only for isolated single cycles. Register accesses are one per cycle and never overlap, which keeps the combinational read data meaningful when it is sampled at the falling edge.

// File: rtl/shm_db_pkg.sv
`timescale 1ns/1ps
package shm_db_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MASK,
    SEL_STAT,
    SEL_ID,
    SEL_BELL
  } reg_sel_e;

  // word indexes (byte offset / 4) of the four registers
  localparam int unsigned WORD_MASK = 0;
  localparam int unsigned WORD_STAT = 1;
  localparam int unsigned WORD_ID   = 2;
  localparam int unsigned WORD_BELL = 3;
endpackage

// File: rtl/shm_db_decode.sv
`timescale 1ns/1ps
module shm_db_decode
  import shm_db_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic [AW-1:0] addr,
  output reg_sel_e      sel
);
  localparam int unsigned WW = AW - 2;

  logic [WW-1:0] word;
  assign word = addr[AW-1:2];

  always_comb begin
    sel = SEL_NONE;
    if (addr[1:0] == 2'b00) begin
      if (word == WW'(WORD_MASK))      sel = SEL_MASK;
      else if (word == WW'(WORD_STAT)) sel = SEL_STAT;
      else if (word == WW'(WORD_ID))   sel = SEL_ID;
      else if (word == WW'(WORD_BELL)) sel = SEL_BELL;
    end
  end
endmodule

// File: rtl/shm_db_outbox.sv
`timescale 1ns/1ps
module shm_db_outbox #(
  parameter int unsigned ID_W  = 16,
  parameter int unsigned VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bell_wr,
  input  logic             id_ready,
  input  logic [ID_W-1:0]  wr_dest,
  input  logic [VEC_W-1:0] wr_vec,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ID_W-1:0]  out_dest,
  output logic [VEC_W-1:0] out_vec
);
  logic slot_free;
  logic load;

  assign slot_free = !out_valid || out_ready;
  assign load      = bell_wr && id_ready && slot_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_dest  <= '0;
      out_vec   <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_dest  <= wr_dest;
      out_vec   <= wr_vec;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R5: a stalled event holds its payload
  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_dest) && $stable(out_vec)));

  // R6: no event appears from a write made while not ready
  p_no_send_unready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bell_wr && !id_ready && !out_valid) |=> !out_valid);
endmodule

// File: rtl/shm_db_inbound.sv
`timescale 1ns/1ps
module shm_db_inbound #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned VEC_W   = 16,
  parameter int unsigned NUM_VEC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msg_mode,
  input  logic               in_valid,
  input  logic [VEC_W-1:0]   in_vec,
  input  logic               stat_rd,
  output logic [DATA_W-1:0]  status,
  output logic [NUM_VEC-1:0] vec_pulse,
  output logic               vec_err
);
  localparam int unsigned SH_W = $clog2(DATA_W);

  logic              pin_ev;
  logic              msg_ev;
  logic              in_range;
  logic [DATA_W-1:0] set_bits;

  assign pin_ev   = in_valid && !msg_mode;
  assign msg_ev   = in_valid && msg_mode;
  assign in_range = in_vec < VEC_W'(NUM_VEC);
  assign set_bits = pin_ev ? (DATA_W'(1) << in_vec[SH_W-1:0]) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status  <= '0;
      vec_err <= 1'b0;
    end else begin
      status  <= (stat_rd ? '0 : status) | set_bits;
      vec_err <= vec_err | (msg_ev && !in_range);
    end
  end

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
    always_ff @(posedge clk) begin
      if (!rst_n) vec_pulse[g] <= 1'b0;
      else        vec_pulse[g] <= msg_ev && in_range && (in_vec == VEC_W'(g));
    end
  end

  // R7: a pin-mode event leaves status nonzero
  p_status_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pin_ev |=> (status != '0));

  // R10: at most one vector pulse at a time
  p_pulse_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vec_pulse));

  // R10: message mode leaves status alone
  p_msg_no_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_ev && !stat_rd) |=> $stable(status));

  // R11: out-of-range vector raises nothing
  p_bad_vec_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_ev && !in_range) |=> (vec_pulse == '0 && vec_err));

  // R11: error flag is sticky
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    vec_err |=> vec_err);
endmodule

// File: rtl/shm_doorbell_regs.sv
`timescale 1ns/1ps
module shm_doorbell_regs
  import shm_db_pkg::*;
#(
  parameter int unsigned AW      = 10,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ID_W    = 16,
  parameter int unsigned VEC_W   = 16,
  parameter int unsigned NUM_VEC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [ID_W-1:0]    node_id,
  input  logic               id_ready,
  input  logic               msg_mode,
  input  logic               in_valid,
  input  logic [VEC_W-1:0]   in_vec,
  output logic               irq,
  output logic [NUM_VEC-1:0] vec_pulse,
  output logic               vec_err,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ID_W-1:0]    out_dest,
  output logic [VEC_W-1:0]   out_vec
);
  localparam int unsigned DEST_LSB = DATA_W - ID_W;

  reg_sel_e          sel;
  logic              wr;
  logic              rd;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] status;

  assign wr = bus_en && bus_we;
  assign rd = bus_en && !bus_we;

  shm_db_decode #(.AW(AW)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                      mask_q <= '0;
    else if (wr && sel == SEL_MASK)  mask_q <= bus_wdata;
  end

  shm_db_outbox #(.ID_W(ID_W), .VEC_W(VEC_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .bell_wr   (wr && sel == SEL_BELL),
    .id_ready  (id_ready),
    .wr_dest   (bus_wdata[DATA_W-1:DEST_LSB]),
    .wr_vec    (bus_wdata[VEC_W-1:0]),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_dest  (out_dest),
    .out_vec   (out_vec)
  );

  shm_db_inbound #(.DATA_W(DATA_W), .VEC_W(VEC_W), .NUM_VEC(NUM_VEC)) u_in (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_mode  (msg_mode),
    .in_valid  (in_valid),
    .in_vec    (in_vec),
    .stat_rd   (rd && sel == SEL_STAT),
    .status    (status),
    .vec_pulse (vec_pulse),
    .vec_err   (vec_err)
  );

  always_comb begin
    unique case (sel)
      SEL_MASK: bus_rdata = mask_q;
      SEL_STAT: bus_rdata = status;
      SEL_ID:   bus_rdata = id_ready ? DATA_W'(node_id) : '1;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = (status != '0) && mask_q[0];

  // R1: mask changes only through its own write
  p_mask_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && sel == SEL_MASK) |=> $stable(mask_q));

  // R9: masked interrupt never asserts
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_q[0] |-> !irq);
endmodule

// File: tb/shm_doorbell_regs_tb_top.sv
`timescale 1ns/1ps
module shm_doorbell_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] node_id = 16'h1234;
  logic        id_ready = 1'b0, msg_mode = 1'b0, in_valid = 1'b0;
  logic [15:0] in_vec = '0;
  logic        irq, vec_err, out_valid;
  logic        out_ready = 1'b0;
  logic [3:0]  vec_pulse;
  logic [15:0] out_dest, out_vec;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  shm_doorbell_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .node_id(node_id), .id_ready(id_ready), .msg_mode(msg_mode),
    .in_valid(in_valid), .in_vec(in_vec), .irq(irq), .vec_pulse(vec_pulse),
    .vec_err(vec_err), .out_valid(out_valid), .out_ready(out_ready),
    .out_dest(out_dest), .out_vec(out_vec)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    #1;
  endtask

  task automatic bus_rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
    #1;
  endtask

  task automatic send_ev(input logic [15:0] v);
    @(negedge clk);
    in_valid = 1'b1; in_vec = v;
    @(negedge clk);
    in_valid = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 mask reset", 32'(irq), 32'd0);
    check("R4 out_valid reset", 32'(out_valid), 32'd0);
    check("R11 vec_err reset", 32'(vec_err), 32'd0);
    bus_rd(10'h000, d); check("R1 mask reads 0", d, 32'h0);
    bus_rd(10'h004, d); check("R7 status reads 0", d, 32'h0);
    bus_rd(10'h008, d); check("R2 id unready", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    bus_wr(10'h000, 32'hA5A5_0001);
    bus_rd(10'h000, d); check("R1 mask readback", d, 32'hA5A5_0001);
    bus_wr(10'h000, 32'h0);
  endtask

  task automatic t_id();
    logic [31:0] d;
    id_ready = 1'b1;
    bus_rd(10'h008, d); check("R2 id ready", d, 32'h0000_1234);
    bus_wr(10'h008, 32'hDEAD_BEEF);
    bus_rd(10'h008, d); check("R2 id write ignored", d, 32'h0000_1234);
  endtask

  task automatic t_unused();
    logic [31:0] d;
    bus_wr(10'h000, 32'h0000_00F0);
    bus_wr(10'h040, 32'hFFFF_FFFF);
    bus_wr(10'h001, 32'hFFFF_FFFF);
    bus_rd(10'h040, d); check("R3 unused reads 0", d, 32'h0);
    bus_rd(10'h3FC, d); check("R3 top word reads 0", d, 32'h0);
    bus_rd(10'h002, d); check("R3 misaligned reads 0", d, 32'h0);
    bus_rd(10'h000, d); check("R3 mask untouched", d, 32'h0000_00F0);
    bus_wr(10'h000, 32'h0);
  endtask

  task automatic t_bell();
    logic [31:0] d;
    bus_wr(10'h00C, 32'h0007_0003);
    check("R4 out_valid", 32'(out_valid), 32'd1);
    check("R4 out_dest", 32'(out_dest), 32'h7);
    check("R4 out_vec", 32'(out_vec), 32'h3);
    bus_rd(10'h00C, d); check("R3 doorbell reads 0", d, 32'h0);
    bus_wr(10'h00C, 32'h0009_0001);
    check("R5 held valid", 32'(out_valid), 32'd1);
    check("R5 held dest", 32'(out_dest), 32'h7);
    check("R5 held vec", 32'(out_vec), 32'h3);
    @(negedge clk); out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
    #1 check("R5 accepted", 32'(out_valid), 32'd0);
  endtask

  task automatic t_unready();
    id_ready = 1'b0;
    bus_wr(10'h00C, 32'h0005_0002);
    check("R6 no event", 32'(out_valid), 32'd0);
    @(negedge clk); #1 check("R6 still no event", 32'(out_valid), 32'd0);
    id_ready = 1'b1;
  endtask

  task automatic t_pin();
    logic [31:0] d;
    msg_mode = 1'b0;
    bus_wr(10'h000, 32'h1);
    send_ev(16'd5);
    check("R9 irq raised", 32'(irq), 32'd1);
    bus_rd(10'h004, d); check("R7 status bit5", d, 32'h0000_0020);
    check("R8 irq after clear", 32'(irq), 32'd0);
    bus_rd(10'h004, d); check("R8 status cleared", d, 32'h0);
    bus_wr(10'h000, 32'h0);
    send_ev(16'd33);
    check("R9 masked irq", 32'(irq), 32'd0);
    bus_wr(10'h004, 32'hFFFF_FFFF);
    bus_wr(10'h000, 32'h1);
    check("R9 unmask irq", 32'(irq), 32'd1);
    bus_rd(10'h004, d); check("R7 status wraps vec, write ignored", d, 32'h0000_0002);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    send_ev(16'd2);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = 10'h004;
    in_valid = 1'b1; in_vec = 16'd4;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0; in_valid = 1'b0;
    check("R8 read value", d, 32'h0000_0004);
    bus_rd(10'h004, d); check("R8 new bit survives", d, 32'h0000_0010);
  endtask

  task automatic t_msg();
    logic [31:0] d;
    msg_mode = 1'b1;
    send_ev(16'd2);
    check("R10 pulse vec2", 32'(vec_pulse), 32'h4);
    @(negedge clk); #1 check("R10 pulse one cycle", 32'(vec_pulse), 32'h0);
    send_ev(16'd0);
    check("R10 pulse vec0", 32'(vec_pulse), 32'h1);
    bus_rd(10'h004, d); check("R10 status untouched", d, 32'h0);
    check("R10 no irq", 32'(irq), 32'd0);
    check("R11 no error yet", 32'(vec_err), 32'd0);
    send_ev(16'd4);
    check("R11 no pulse", 32'(vec_pulse), 32'h0);
    check("R11 err set", 32'(vec_err), 32'd1);
    send_ev(16'd3);
    check("R10 pulse vec3", 32'(vec_pulse), 32'h8);
    check("R11 err sticky", 32'(vec_err), 32'd1);
    msg_mode = 1'b0;
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_mask();
    t_id();
    t_unused();
    t_bell();
    t_unready();
    t_pin();
    t_collide();
    t_msg();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule